// File: doc/BRIEF.md
# Windowed Frame Autocorrelation Engine

This block takes one frame of 450 pre-emphasised 16-bit speech samples. It tapers each sample with a Hamming window held in an internal constant table and keeps the windowed frame in local storage. From that stored frame it computes the short-term autocorrelation for lags 0 to 10. Those eleven sums are the input to a linear-prediction stage further down the chain. A single multiply-accumulate unit walks the lags in ascending order. Each lag's sum covers one product fewer than the lag before it.

A frame opens with a sample flagged as the start while the engine is idle. The remaining samples follow on any cycles where the valid input is high, and gaps are allowed. Once the frame is stored, the engine streams eleven 48-bit coefficients, each one tagged with its lag, and flags the final one. The lag-0 sum is the frame energy. The engine also holds it on a dedicated output until the next frame replaces it. A busy output covers the whole period from the first sample to the last coefficient, and any input offered during that period is discarded.

Top module: `speech_acorr`

## Requirements
- R1: After reset, busy, res_valid and res_last are low and frame_energy reads zero.
- R2: While idle, a cycle with in_valid and in_start high stores in_sample as frame position 0. After that, each cycle with in_valid high stores the next position, 1 up to 449, regardless of in_start. Cycles with in_valid low store nothing.
- R3: Position n is scaled by the unsigned Q1.15 coefficient w(n) = round(32768·(0.54 − 0.46·cos(2πn/449))), limited to 32767. The windowed value is (in_sample·w(n) + 16384) shifted right arithmetically by 15.
- R4: For lag m, the result is the exact signed sum over n = 0 … 449−m of x(n)·x(n+m), where x is the windowed frame, given as a 48-bit two's-complement value on res_coef.
- R5: Each frame yields exactly eleven single-cycle res_valid pulses. Their 4-bit res_lag values run 0, 1, …, 10 in that order, and res_last is high only on the pulse whose lag is 10.
- R6: The cycle after the lag-0 result, frame_energy takes that lag-0 value. It holds it unchanged until the next frame's lag-0 result.
- R7: busy rises the cycle after the start sample is stored. It stays high through the cycle showing the lag-10 result and is low on the following cycle. Every res_valid pulse falls within busy.
- R8: While busy is high, in_valid, in_start and in_sample have no effect on any result.
- R9: While idle, a cycle with in_valid high and in_start low is discarded and does not start a frame.
- R10: The lag-10 result appears between 4895 and 4901 clock cycles after the cycle in which the final sample of the frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered this cycle |
| in_start | input | 1 | Marks the offered sample as the first of a frame (used only while idle) |
| in_sample | input | 16 | Signed pre-emphasised sample |
| busy | output | 1 | Frame is being loaded or processed |
| res_valid | output | 1 | A coefficient is present this cycle |
| res_lag | output | 4 | Lag index of the presented coefficient |
| res_coef | output | 48 | Signed autocorrelation value |
| res_last | output | 1 | Presented coefficient is the final (lag 10) one |
| frame_energy | output | 48 | Lag-0 sum of the most recent frame |

## Verification
An all-zero frame shows that no stale accumulator value leaks into a sum. Frames held at the largest positive and negative values exercise the window saturation and the full width of the accumulator. A tone that alternates in sign checks the sign handling on odd lags. Two sparse frames expose any off-by-one in frame indexing or in the shrinking sum range. One places pulse pairs three apart in the middle of the frame, the other places a pair four apart at its tail. Random frames then mix in idle noise, gaps inside the frame, a spurious start flag during loading, and junk offered while busy, to check that the capture and discard rules hold.

// File: rtl/speech_acorr_pkg.sv
package speech_acorr_pkg;

    // Datapath widths
    localparam int unsigned SAMPLE_W  = 16;
    localparam int unsigned COEF_W    = 16;
    localparam int unsigned ACC_W     = 48;
    localparam int unsigned ORDER_DEF = 10;
    localparam int unsigned FRAME_DEF = 450;
    localparam int unsigned LAG_W     = $clog2(ORDER_DEF + 1);
    localparam int unsigned PROD_W    = 2 * SAMPLE_W;
    localparam int unsigned WPROD_W   = SAMPLE_W + COEF_W + 1;
    localparam int unsigned FRAC_BITS = COEF_W - 1;

    localparam real PI_R = 3.14159265358979323846;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic        [COEF_W-1:0]   wcoef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic        [LAG_W-1:0]    lag_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC
    } ctl_state_e;

    // Operand pair captured from the frame store, with sequencing tags
    typedef struct packed {
        logic    vld;
        logic    first;
        logic    tail;
        lag_t    lag;
        sample_t opa;
        sample_t opb;
    } mac_op_t;

    // Coefficient presented at the result port
    typedef struct packed {
        logic vld;
        logic last;
        lag_t lag;
        acc_t value;
    } acorr_res_t;

    // Hamming taper value for one position, unsigned Q1.15, clamped below 1.0
    function automatic wcoef_t hamming_q15(input int unsigned idx, input int unsigned len);
        real ang;
        real wr;
        int  q;
        ang = 2.0 * PI_R * real'(idx) / real'(len - 1);
        wr  = 0.54 - 0.46 * $cos(ang);
        q   = $rtoi(wr * 32768.0 + 0.5);
        if (q > 32767) q = 32767;
        return wcoef_t'(q);
    endfunction

    // Signed sample times unsigned taper, rounded back to sample width
    function automatic sample_t apply_taper(input sample_t s, input wcoef_t w);
        logic signed [WPROD_W-1:0] prod;
        prod = WPROD_W'(s) * WPROD_W'($signed({1'b0, w}));
        prod = prod + WPROD_W'(1 << (FRAC_BITS - 1));
        return prod[FRAC_BITS +: SAMPLE_W];
    endfunction

endpackage

// File: rtl/acorr_window_rom.sv
module acorr_window_rom
    import speech_acorr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_DEF
) (
    input  logic [$clog2(FRAME_LEN)-1:0] idx,
    output wcoef_t                       coef
);

    wcoef_t table_w [FRAME_LEN];

    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_entry
        localparam wcoef_t ENTRY = hamming_q15(i, FRAME_LEN);
        assign table_w[i] = ENTRY;
    end

    always_comb begin
        coef = '0;
        if (int'(idx) < int'(FRAME_LEN)) coef = table_w[idx];
    end

endmodule

// File: rtl/acorr_frame_mem.sv
module acorr_frame_mem
    import speech_acorr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_DEF
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [$clog2(FRAME_LEN)-1:0] wr_addr,
    input  sample_t                      wr_data,
    input  logic [$clog2(FRAME_LEN)-1:0] rd_addr_a,
    input  logic [$clog2(FRAME_LEN)-1:0] rd_addr_b,
    output sample_t                      rd_data_a,
    output sample_t                      rd_data_b
);

    sample_t mem_q [FRAME_LEN];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < int'(FRAME_LEN))) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        if (int'(rd_addr_a) < int'(FRAME_LEN)) rd_data_a = mem_q[rd_addr_a];
        if (int'(rd_addr_b) < int'(FRAME_LEN)) rd_data_b = mem_q[rd_addr_b];
    end

endmodule

// File: rtl/acorr_mac_seq.sv
module acorr_mac_seq
    import speech_acorr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_DEF,
    parameter int unsigned ORDER     = ORDER_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         kick,
    output logic [$clog2(FRAME_LEN)-1:0] rd_addr_a,
    output logic [$clog2(FRAME_LEN)-1:0] rd_addr_b,
    input  sample_t                      rd_data_a,
    input  sample_t                      rd_data_b,
    output acorr_res_t                   res
);

    localparam int unsigned IDX_W = $clog2(FRAME_LEN);

    logic                running_q;
    lag_t                lag_q;
    logic [IDX_W-1:0]    pos_q;
    logic [IDX_W-1:0]    span_end;
    logic                at_end;
    mac_op_t             op_q;
    acc_t                acc_q;
    acc_t                acc_next;
    logic signed [PROD_W-1:0] prod;

    // Last position of the current lag: the sum range shrinks by one per lag
    assign span_end  = IDX_W'(int'(FRAME_LEN) - 1 - int'(lag_q));
    assign at_end    = (pos_q == span_end);
    assign rd_addr_a = pos_q;
    assign rd_addr_b = pos_q + IDX_W'(lag_q);

    // Stage A: walk positions and lags, capture operand pairs
    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            lag_q     <= '0;
            pos_q     <= '0;
            op_q      <= '0;
        end else begin
            op_q.vld   <= running_q;
            op_q.first <= (pos_q == '0);
            op_q.tail  <= at_end;
            op_q.lag   <= lag_q;
            op_q.opa   <= rd_data_a;
            op_q.opb   <= rd_data_b;
            if (kick) begin
                running_q <= 1'b1;
                lag_q     <= '0;
                pos_q     <= '0;
            end else if (running_q) begin
                if (at_end) begin
                    pos_q <= '0;
                    if (lag_q == LAG_W'(ORDER)) begin
                        running_q <= 1'b0;
                        lag_q     <= '0;
                    end else begin
                        lag_q <= lag_q + 1'b1;
                    end
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // Stage B: multiply and accumulate, present a coefficient at each lag tail
    always_comb begin
        prod     = PROD_W'(op_q.opa) * PROD_W'(op_q.opb);
        acc_next = (op_q.first ? '0 : acc_q) + ACC_W'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res   <= '0;
        end else begin
            if (op_q.vld) acc_q <= acc_next;
            res.vld   <= op_q.vld && op_q.tail;
            res.last  <= op_q.vld && op_q.tail && (op_q.lag == LAG_W'(ORDER));
            res.lag   <= op_q.lag;
            res.value <= acc_next;
        end
    end

endmodule

// File: rtl/speech_acorr.sv
module speech_acorr
    import speech_acorr_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_DEF,
    parameter int unsigned ORDER     = ORDER_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_start,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       busy,
    output logic                       res_valid,
    output logic [LAG_W-1:0]           res_lag,
    output logic signed [ACC_W-1:0]    res_coef,
    output logic                       res_last,
    output logic signed [ACC_W-1:0]    frame_energy
);

    localparam int unsigned IDX_W = $clog2(FRAME_LEN);

    ctl_state_e       st_q;
    logic [IDX_W-1:0] load_cnt_q;
    logic             kick_q;
    acc_t             energy_q;

    logic             take_first;
    logic             take_next;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    wcoef_t           taper;
    sample_t          wr_data;
    logic [IDX_W-1:0] rd_addr_a;
    logic [IDX_W-1:0] rd_addr_b;
    sample_t          rd_data_a;
    sample_t          rd_data_b;
    acorr_res_t       res;

    // Frame capture: start flag honoured only while idle
    assign take_first = (st_q == ST_IDLE) && in_valid && in_start;
    assign take_next  = (st_q == ST_LOAD) && in_valid;
    assign wr_en      = take_first || take_next;
    assign wr_addr    = take_first ? '0 : load_cnt_q;
    assign wr_data    = apply_taper(in_sample, taper);

    acorr_window_rom #(.FRAME_LEN(FRAME_LEN)) u_rom (
        .idx  (wr_addr),
        .coef (taper)
    );

    acorr_frame_mem #(.FRAME_LEN(FRAME_LEN)) u_mem (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    acorr_mac_seq #(.FRAME_LEN(FRAME_LEN), .ORDER(ORDER)) u_mac (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick_q),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            load_cnt_q <= '0;
            kick_q     <= 1'b0;
            energy_q   <= '0;
        end else begin
            kick_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (take_first) begin
                        st_q       <= ST_LOAD;
                        load_cnt_q <= IDX_W'(1);
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        if (load_cnt_q == IDX_W'(FRAME_LEN - 1)) begin
                            st_q   <= ST_CALC;
                            kick_q <= 1'b1;
                        end else begin
                            load_cnt_q <= load_cnt_q + 1'b1;
                        end
                    end
                end
                ST_CALC: begin
                    if (res.vld && res.last) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (res.vld && (res.lag == '0)) energy_q <= res.value;
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign res_valid    = res.vld;
    assign res_lag      = res.lag;
    assign res_coef     = res.value;
    assign res_last     = res.last;
    assign frame_energy = energy_q;

endmodule

// File: rtl/speech_acorr_chk.sv
module speech_acorr_chk
    import speech_acorr_pkg::*;
#(
    parameter int unsigned ORDER = ORDER_DEF
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    busy,
    input logic                    res_valid,
    input logic [LAG_W-1:0]        res_lag,
    input logic signed [ACC_W-1:0] res_coef,
    input logic                    res_last,
    input logic signed [ACC_W-1:0] frame_energy
);

    // R5: lags never exceed the order
    a_r5_lag_in_range: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_lag <= LAG_W'(ORDER)));

    // R5: the final flag marks only the highest lag
    a_r5_last_on_top_lag: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_last) |-> (res_lag == LAG_W'(ORDER)));

    // R7: results appear only inside the busy window
    a_r7_result_within_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);

    // R7: busy drops right after the final coefficient
    a_r7_release_after_last: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_last) |=> !busy);

    // R6: energy captures the lag-0 sum
    a_r6_energy_capture: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_lag == '0)) |=> (frame_energy == $past(res_coef)));

    // R6: energy holds otherwise
    a_r6_energy_hold: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && (res_lag == '0)) |=> $stable(frame_energy));

    // R4: a sum of squares is never negative
    a_r4_energy_nonneg: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_lag == '0)) |-> !res_coef[ACC_W-1]);

endmodule

bind speech_acorr speech_acorr_chk #(.ORDER(ORDER)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .res_valid    (res_valid),
    .res_lag      (res_lag),
    .res_coef     (res_coef),
    .res_last     (res_last),
    .frame_energy (frame_energy)
);

// File: tb/speech_acorr_tb_top.sv
module speech_acorr_tb_top;

    localparam int NLEN = 450;
    localparam int NLAG = 11;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_start = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               busy;
    logic               res_valid;
    logic [3:0]         res_lag;
    logic signed [47:0] res_coef;
    logic               res_last;
    logic signed [47:0] frame_energy;

    int     tests = 0;
    int     fails = 0;
    int     cyc   = 0;
    int     frm   [NLEN];
    longint expv  [NLAG];
    longint gotv  [NLAG];
    int     got_cnt  = 0;
    int     done_cnt = 0;
    int     seq_bad  = 0;
    int     busy_bad = 0;

    speech_acorr dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_start     (in_start),
        .in_sample    (in_sample),
        .busy         (busy),
        .res_valid    (res_valid),
        .res_lag      (res_lag),
        .res_coef     (res_coef),
        .res_last     (res_last),
        .frame_energy (frame_energy)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Taper from the formula in R3
    function automatic int taper(input int n);
        real ang;
        real wr;
        int  q;
        ang = 2.0 * 3.14159265358979323846 * real'(n) / real'(NLEN - 1);
        wr  = 0.54 - 0.46 * $cos(ang);
        q   = $rtoi(wr * 32768.0 + 0.5);
        if (q > 32767) q = 32767;
        return q;
    endfunction

    function automatic longint shaped(input int s, input int n);
        longint p;
        p = longint'(s) * longint'(taper(n)) + 64'sd16384;
        return p >>> 15;
    endfunction

    // Expected coefficients from R4
    task automatic compute_expected();
        longint x [NLEN];
        for (int n = 0; n < NLEN; n++) x[n] = shaped(frm[n], n);
        for (int m = 0; m < NLAG; m++) begin
            expv[m] = 0;
            for (int n = 0; n <= NLEN - 1 - m; n++) expv[m] += x[n] * x[n + m];
        end
    endtask

    // Result monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst && res_valid) begin
            if (got_cnt < NLAG) begin
                gotv[got_cnt] = res_coef;
                if (res_lag != 4'(got_cnt)) seq_bad++;
                if (res_last != (got_cnt == NLAG - 1)) seq_bad++;
            end else begin
                seq_bad++;
            end
            if (!busy) busy_bad++;
            got_cnt++;
            if (res_last) done_cnt++;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_frame(input string tag, input bit gaps, input bit junk, input bit idle_noise);
        int     d0;
        int     lat;
        longint prev_energy;
        compute_expected();
        prev_energy = frame_energy;
        if (idle_noise) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_start  = 1'b0;
                in_sample = 16'($urandom);
            end
            @(negedge clk);
            in_valid = 1'b0;
            check(busy == 1'b0, {"R9 idle sample started frame ", tag}, busy, 0);
            check(frame_energy == prev_energy, {"R6 energy held while idle ", tag}, frame_energy, prev_energy);
        end
        got_cnt  = 0;
        seq_bad  = 0;
        busy_bad = 0;
        d0 = done_cnt;
        @(negedge clk);
        check(busy == 1'b0, {"R7 busy low before start ", tag}, busy, 0);
        in_valid  = 1'b1;
        in_start  = 1'b1;
        in_sample = 16'(frm[0]);
        for (int i = 1; i < NLEN; i++) begin
            if (gaps && ($urandom % 5 == 0)) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_start  = 1'($urandom);
                in_sample = 16'($urandom);
            end
            @(negedge clk);
            if (i == 1) check(busy == 1'b1, {"R7 busy after start ", tag}, busy, 1);
            in_valid  = 1'b1;
            in_start  = gaps ? 1'($urandom) : 1'b0;
            in_sample = 16'(frm[i]);
        end
        lat = 0;
        while (done_cnt == d0 && lat < 6000) begin
            @(negedge clk);
            lat++;
            if (junk && busy) begin
                in_valid  = 1'($urandom);
                in_start  = 1'($urandom);
                in_sample = 16'($urandom);
            end else begin
                in_valid = 1'b0;
                in_start = 1'b0;
            end
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        check(lat >= 4895 && lat <= 4901, {"R10 latency ", tag}, lat, 4897);
        check(seq_bad == 0 && got_cnt == NLAG, {"R5 lag order and count ", tag}, got_cnt, NLAG);
        check(busy_bad == 0, {"R7 result outside busy ", tag}, busy_bad, 0);
        for (int m = 0; m < NLAG; m++) begin
            check(gotv[m] == expv[m], $sformatf("R4 R3 R2 R8 lag %0d %s", m, tag), gotv[m], expv[m]);
        end
        @(negedge clk);
        check(busy == 1'b0, {"R7 busy low after last ", tag}, busy, 0);
        check(frame_energy == expv[0], {"R6 energy equals lag0 ", tag}, frame_energy, expv[0]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(res_valid == 1'b0 && res_last == 1'b0, "R1 result idle after reset", res_valid, 0);
        check(frame_energy == 0, "R1 energy after reset", frame_energy, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int n = 0; n < NLEN; n++) frm[n] = 0;
        run_frame("zero", 1'b0, 1'b0, 1'b0);

        for (int n = 0; n < NLEN; n++) frm[n] = 32767;
        run_frame("maxpos", 1'b0, 1'b0, 1'b0);

        for (int n = 0; n < NLEN; n++) frm[n] = -32768;
        run_frame("maxneg", 1'b0, 1'b1, 1'b0);

        for (int n = 0; n < NLEN; n++) frm[n] = (n % 2 == 0) ? 20000 : -20000;
        run_frame("alternate", 1'b1, 1'b0, 1'b0);

        for (int n = 0; n < NLEN; n++) frm[n] = 0;
        frm[200] = 30000;
        frm[203] = -25000;
        run_frame("pulses_mid", 1'b0, 1'b0, 1'b1);

        for (int n = 0; n < NLEN; n++) frm[n] = 0;
        frm[445] = 31000;
        frm[449] = 29000;
        frm[0]   = 27000;
        run_frame("pulses_tail", 1'b1, 1'b1, 1'b0);

        for (int f = 0; f < 3; f++) begin
            for (int n = 0; n < NLEN; n++) frm[n] = int'($urandom % 65536) - 32768;
            run_frame($sformatf("random%0d", f), 1'b1, 1'b1, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule